// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block turns one block-transfer command into a string of single-word memory beats. A command carries a base address, a 16-bit selection of registers, a direction flag (load or store) and a request to write the base back. The sequencer emits one beat per selected register. Each beat carries the word address and the register index, and moves over a valid/ready handshake. Registers go out lowest index first. The address starts at the base and then rises by one word after every accepted beat.

The same command port also takes a single pre-indexed transfer. For that form the block adds a signed immediate offset to the base, emits exactly one beat at that sum, and offers the sum as the new base value. When a command finishes, the block raises a one-cycle completion pulse. With that pulse it reports the updated base, whether that base is to be written back, and whether a writeback was refused because the base register was the program counter (index 15).

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1 while `beat_valid` and `done` are 0.
- R2: For a multiple transfer, the first beat carries `beat_addr` equal to `cmd_base`, unchanged.
- R3: A multiple transfer emits exactly one beat for each set bit of `cmd_mask`. Bit i selects register i. `beat_reg` runs through the set bits in strictly ascending order, starting from the lowest.
- R4: Within a multiple transfer, each beat's address is 4 bytes higher than the previous one, wrapping modulo 2^32.
- R5: While `beat_valid` is 1 and `beat_ready` is 0, the signals `beat_valid`, `beat_addr`, `beat_reg` and `beat_load` hold their values into the next cycle.
- R6: `cmd_ready` is 0 from the accepting edge until `done`. `done` is high for exactly one cycle, namely the cycle right after the edge that accepted the last beat.
- R7: When a multiple transfer completes, `done_base` equals `cmd_base` + 4 × (number of set mask bits), and `done_wb` equals `cmd_wb` (unless R11 applies).
- R8: With `cmd_wb` = 0, `done_wb` is 0 at completion.
- R9: A multiple transfer with an all-zero mask emits no beat. `done` rises in the cycle after acceptance and `done_base` equals `cmd_base`.
- R10: With `cmd_single` = 1, exactly one beat is emitted. Its address is `cmd_base` + sign-extended `cmd_offset` (12-bit two's complement) and its register is `cmd_rd`. `done_base` equals that same sum.
- R11: With `cmd_wb` = 1 and `cmd_base_idx` = 15, `done_err` is 1 and `done_wb` is 0 at completion. In every other case `done_err` is 0.
- R12: `beat_load` equals the command's `cmd_load` on every beat of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted on valid |
| cmd_base | input | 32 | Base address |
| cmd_mask | input | 16 | Register selection, bit i = register i |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_wb | input | 1 | Request writeback of the updated base |
| cmd_base_idx | input | 4 | Index of the base register |
| cmd_single | input | 1 | Single pre-indexed transfer |
| cmd_offset | input | 12 | Signed offset for the single form |
| cmd_rd | input | 4 | Register of the single form |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken downstream |
| beat_addr | output | 32 | Word address of the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_load | output | 1 | Direction of the beat |
| done | output | 1 | One-cycle completion pulse |
| done_base | output | 32 | Updated base value, valid with done |
| done_wb | output | 1 | Base is to be written back, valid with done |
| done_err | output | 1 | Writeback refused for register 15, valid with done |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 16 registers and a 12-bit offset. These values make the register-15 writeback refusal reachable, and the full-mask case has sixteen back-to-back beats. A 12-bit offset with its sign bit set exercises the negative pre-index path. Directed bases near the top of the address space show that the word step wraps. Random stall patterns on `beat_ready` show that beats are held and that the done pulse waits for the last accepted beat.

// File: rtl/xfer_seq_pkg.sv
// Shared types for the block-transfer sequencer.
package xfer_seq_pkg;
    // Sequencer phase: waiting for a command, issuing beats, reporting completion.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/xfer_seq_pick.sv
// Lowest-set-bit finder.
// Returns the index of the least significant set bit of vec and whether any bit is set.
// Assumes N is at least 2; purely combinational.
module xfer_seq_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    // Flag a non-empty vector.
    assign any = |vec;
endmodule

// File: rtl/xfer_seq_addr.sv
// Transfer address register.
// On load it takes the base, or base plus the sign-extended offset for the single form.
// On each step it advances by STEP bytes. Assumes load and step are never high together.
module xfer_seq_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              single,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              step_en,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    // Sign-extend the immediate offset to the address width.
    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};

    // Hold the running address; load at command start, advance per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load_en) begin
            cur_addr <= single ? (base + off_ext) : base;
        end else if (step_en) begin
            cur_addr <= cur_addr + ADDR_W'(STEP);
        end
    end
endmodule

// File: rtl/xfer_seq.sv
// Block-transfer address sequencer (top).
// Accepts one command while idle. For a multiple transfer it walks the register mask
// lowest index first with increment-after addressing, one beat per set bit. For the
// single form it issues one beat at base plus offset. After the last accepted beat it
// pulses done with the updated base and the writeback decision; writeback is refused
// when the base register is the highest index (program counter).
// Assumes cmd_* inputs are stable only in the accepting cycle.
module xfer_seq #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int OFF_W  = 12,
    parameter int STEP   = 4,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [NREG-1:0]   cmd_mask,
    input  logic              cmd_load,
    input  logic              cmd_wb,
    input  logic [IDX_W-1:0]  cmd_base_idx,
    input  logic              cmd_single,
    input  logic [OFF_W-1:0]  cmd_offset,
    input  logic [IDX_W-1:0]  cmd_rd,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [IDX_W-1:0]  beat_reg,
    output logic              beat_load,
    output logic              done,
    output logic [ADDR_W-1:0] done_base,
    output logic              done_wb,
    output logic              done_err
);
    import xfer_seq_pkg::*;

    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NREG - 1);

    seq_state_t       state_q;
    logic [NREG-1:0]  mask_q;
    logic [NREG-1:0]  start_mask;
    logic [NREG-1:0]  mask_next;
    logic             load_q;
    logic             single_q;
    logic             wb_q;
    logic             err_q;
    logic             accept_cmd;
    logic             accept_beat;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    logic [ADDR_W-1:0] cur_addr;

    // Command and beat handshakes.
    assign cmd_ready   = (state_q == ST_IDLE);
    assign accept_cmd  = cmd_valid && cmd_ready;
    assign beat_valid  = (state_q == ST_BEAT);
    assign accept_beat = beat_valid && beat_ready;

    // Single form becomes a one-hot mask so one walk serves both forms.
    assign start_mask = cmd_single ? (NREG'(1) << cmd_rd) : cmd_mask;

    // Remaining mask once the current lowest register is retired.
    assign mask_next = mask_q & ~(NREG'(1) << pick_idx);

    xfer_seq_pick #(
        .N     (NREG),
        .IDX_W (IDX_W)
    ) u_pick (
        .vec (mask_q),
        .idx (pick_idx),
        .any (pick_any)
    );

    xfer_seq_addr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .STEP   (STEP)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (accept_cmd),
        .single   (cmd_single),
        .base     (cmd_base),
        .offset   (cmd_offset),
        .step_en  (accept_beat && !single_q),
        .cur_addr (cur_addr)
    );

    // Phase sequencing: idle -> beats -> done pulse -> idle; empty mask skips beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept_cmd) state_q <= (|start_mask) ? ST_BEAT : ST_DONE;
                ST_BEAT: if (accept_beat && (mask_next == '0)) state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Remaining-register mask: captured at start, one bit cleared per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (accept_cmd) begin
            mask_q <= start_mask;
        end else if (accept_beat) begin
            mask_q <= mask_next;
        end
    end

    // Command attributes held for the whole command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= 1'b0;
            single_q <= 1'b0;
            wb_q     <= 1'b0;
            err_q    <= 1'b0;
        end else if (accept_cmd) begin
            load_q   <= cmd_load;
            single_q <= cmd_single;
            wb_q     <= cmd_wb && (cmd_base_idx != PC_IDX);
            err_q    <= cmd_wb && (cmd_base_idx == PC_IDX);
        end
    end

    // Beat fields; pick_any is always true while beats are issued.
    assign beat_addr = cur_addr;
    assign beat_reg  = pick_any ? pick_idx : '0;
    assign beat_load = load_q;

    // Completion report, qualified by the done phase.
    assign done      = (state_q == ST_DONE);
    assign done_base = cur_addr;
    assign done_wb   = done && wb_q;
    assign done_err  = done && err_q;
endmodule

// File: rtl/xfer_seq_chk.sv
// Protocol checker for xfer_seq, attached with bind. Observes ports only.
module xfer_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [IDX_W-1:0]  beat_reg,
    input logic              beat_load,
    input logic              done,
    input logic              done_wb,
    input logic              done_err
);
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg) && $stable(beat_load))); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready) |=> (!beat_valid || (beat_addr == $past(beat_addr) + ADDR_W'(STEP)))); // R4
    AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready) |=> (!beat_valid || (beat_reg > $past(beat_reg)))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid || done) |-> !cmd_ready); // R6
    AST_PC_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> (done && !done_wb)); // R11
endmodule

bind xfer_seq xfer_seq_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .STEP   (STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_reg   (beat_reg),
    .beat_load  (beat_load),
    .done       (done),
    .done_wb    (done_wb),
    .done_err   (done_err)
);

// File: tb/xfer_seq_bench.sv
// Self-checking bench: directed corners plus seeded random commands and stalls.
module xfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_mask = '0;
    logic        cmd_load = 1'b0;
    logic        cmd_wb = 1'b0;
    logic [3:0]  cmd_base_idx = '0;
    logic        cmd_single = 1'b0;
    logic [11:0] cmd_offset = '0;
    logic [3:0]  cmd_rd = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [3:0]  beat_reg;
    logic        beat_load;
    logic        done;
    logic [31:0] done_base;
    logic        done_wb;
    logic        done_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    xfer_seq u_xfer_seq (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_base (cmd_base), .cmd_mask (cmd_mask), .cmd_load (cmd_load),
        .cmd_wb (cmd_wb), .cmd_base_idx (cmd_base_idx), .cmd_single (cmd_single),
        .cmd_offset (cmd_offset), .cmd_rd (cmd_rd),
        .beat_valid (beat_valid), .beat_ready (beat_ready),
        .beat_addr (beat_addr), .beat_reg (beat_reg), .beat_load (beat_load),
        .done (done), .done_base (done_base), .done_wb (done_wb), .done_err (done_err)
    );

    // Record one comparison.
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Index of the lowest set bit, or -1.
    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return -1;
    endfunction

    // Base plus sign-extended 12-bit offset.
    function automatic logic [31:0] pre_index(input logic [31:0] b, input logic [11:0] o);
        return b + {{20{o[11]}}, o};
    endfunction

    // Issue one command, drive random stalls, compare every beat and the completion.
    task automatic run_cmd(input logic [31:0] base, input logic [15:0] mask, input bit ld,
                           input bit wb, input logic [3:0] bidx, input bit single,
                           input logic [11:0] off, input logic [3:0] rd, input int stall_pct);
        logic [15:0] rem;
        logic [31:0] addr0;
        logic [31:0] exp_base;
        int nsel;
        int k;
        int cyc;
        bit last_acc;
        bit seen;
        rem      = single ? (16'h1 << rd) : mask;
        nsel     = $countones(rem);
        addr0    = single ? pre_index(base, off) : base;
        exp_base = single ? addr0 : base + 32'(4 * nsel);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R6 idle ready", longint'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_base = base; cmd_mask = mask; cmd_load = ld; cmd_wb = wb;
        cmd_base_idx = bidx; cmd_single = single; cmd_offset = off; cmd_rd = rd;
        last_acc = (nsel == 0);
        k = 0; cyc = 0; seen = 0;
        while (!seen && cyc < 3000) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cmd_mask  = $urandom;
            cyc++;
            if (done) begin
                check(last_acc, "R6 done after last beat", longint'(k), longint'(nsel));
                check(k == nsel, "R3 beat count", longint'(k), longint'(nsel));
                check(done_base == exp_base, single ? "R10 base" : (nsel == 0 ? "R9 base" : "R7 base"),
                      longint'(done_base), longint'(exp_base));
                check(done_wb == (wb && bidx != 4'hF), wb ? "R7 wb" : "R8 wb",
                      longint'(done_wb), longint'(wb && bidx != 4'hF));
                check(done_err == (wb && bidx == 4'hF), "R11 err",
                      longint'(done_err), longint'(wb && bidx == 4'hF));
                check(beat_valid == 1'b0, "R9 no beat with done", longint'(beat_valid), 0);
                seen = 1;
                beat_ready = 1'b0;
            end else begin
                check(!last_acc, "R6 done late", 0, 1);
                check(beat_valid == 1'b1, "R3 beat expected", longint'(beat_valid), 1);
                if (beat_valid && rem != '0) begin
                    check(beat_addr == addr0 + 32'(4 * k),
                          single ? "R10 addr" : (k == 0 ? "R2 addr" : "R4/R5 addr"),
                          longint'(beat_addr), longint'(addr0 + 32'(4 * k)));
                    check(int'(beat_reg) == lowest(rem), single ? "R10 reg" : "R3/R5 reg",
                          longint'(beat_reg), longint'(lowest(rem)));
                    check(beat_load == ld, "R12 load", longint'(beat_load), longint'(ld));
                    check(cmd_ready == 1'b0, "R6 busy", longint'(cmd_ready), 0);
                    beat_ready = ($urandom % 100) >= 32'(stall_pct);
                    if (beat_ready) begin
                        rem[lowest(rem)] = 1'b0;
                        k++;
                        last_acc = (rem == '0);
                    end
                end
            end
        end
        check(seen, "R6 done seen", longint'(seen), 1);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", longint'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1 ready", longint'(cmd_ready), 1);
        check(beat_valid == 1'b0, "R1 valid", longint'(beat_valid), 0);
        check(done == 1'b0, "R1 done", longint'(done), 0);
        // Directed corners.
        run_cmd(32'h0000_1000, 16'h8421, 1, 1, 4'd2, 0, '0, '0, 0);     // R3 sparse, R7
        run_cmd(32'h0000_2000, 16'hFFFF, 0, 1, 4'd13, 0, '0, '0, 60);   // R4/R5 full list
        run_cmd(32'h0000_3000, 16'h0000, 1, 1, 4'd1, 0, '0, '0, 0);     // R9 empty
        run_cmd(32'h0000_4000, 16'h00F0, 1, 0, 4'd3, 0, '0, '0, 30);    // R8
        run_cmd(32'h0000_5000, 16'h0003, 1, 1, 4'd15, 0, '0, '0, 0);    // R11 PC base
        run_cmd(32'hFFFF_FFF8, 16'h0E00, 0, 1, 4'd0, 0, '0, '0, 0);     // R4 wrap
        run_cmd(32'h0000_6000, 16'h0000, 1, 1, 4'd4, 1, 12'h010, 4'd7, 0);  // R10 positive
        run_cmd(32'h0000_6000, 16'h0000, 0, 1, 4'd4, 1, 12'hFFC, 4'd15, 50); // R10 negative
        run_cmd(32'h0000_7000, 16'h0000, 1, 1, 4'd15, 1, 12'h004, 4'd1, 0);  // R11 single
        // Seeded random commands.
        for (int n = 0; n < 150; n++) begin
            run_cmd($urandom & 32'hFFFF_FFFC, ($urandom % 8 == 0) ? 16'h0 : 16'($urandom),
                    1'($urandom), 1'($urandom), 4'($urandom), ($urandom % 4) == 0,
                    12'($urandom), 4'($urandom), int'($urandom % 70));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule